// File: doc/BRIEF.md
# Graceful Packet-Pipeline Pause Controller

This block sits at the entry of a packet-processing pipeline that carries AXI4-Stream traffic. It lets a CPU swap the pipeline's rule registers atomically without double-buffering them. Software sets a pause-request bit in a small flow control register. The block then stops admitting new packets, but only at a packet boundary. It lets everything already inside the pipeline leave, and only then reports a paused status.

Once the status is seen, software may rewrite its tables freely. Clearing the request reopens the entry. Each packet is therefore processed entirely under the rule set that was in force when it entered. The pipeline's output is never stalled to achieve this.

An in-flight packet counter ties the two ends together. It rises on each final beat accepted at the entry and falls on each final beat observed on a monitor tap at the pipeline exit.

Top module: `pkt_pause_gate`

## Requirements
- R1: After reset the pause request is clear, the paused status reads 0, the entry is open and the in-flight count is zero.
- R2: While the entry is open, `pipeTvalid`, `pipeTdata` and `pipeTlast` follow the upstream inputs, and `inTready` equals `pipeTready`.
- R3: With the pause request set and no packet partly admitted, the entry is closed: `pipeTvalid` and `inTready` are both held low whatever `inTvalid` does.
- R4: A pause request made in the middle of a packet lets that packet finish admission up to and including its TLAST beat; the entry closes after that beat.
- R5: The in-flight count rises on each accepted entry beat with TLAST and falls on each exit-tap beat with TVALID, TREADY and TLAST all high; exit beats without TLAST leave it unchanged.
- R6: Register bit 1 (paused status, read-only) is 1 exactly when bit 0 is set, no packet is partly admitted and the in-flight count is zero.
- R7: Writing 0 to bit 0 clears the paused status on the next cycle and reopens the entry in that same cycle.
- R8: Writing 1 to bit 0 while a pause is already requested changes nothing, and the value written to bit 1 is ignored; bits above 1 read as 0.
- R9: An entry TLAST beat and an exit TLAST beat in the same cycle leave the in-flight count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inTvalid | input | 1 | Upstream source beat valid |
| inTready | output | 1 | Ready toward the upstream source |
| inTdata | input | DATA_W | Upstream beat data |
| inTlast | input | 1 | Upstream final beat of packet |
| pipeTvalid | output | 1 | Beat valid into the pipeline |
| pipeTready | input | 1 | Pipeline ready to accept |
| pipeTdata | output | DATA_W | Beat data into the pipeline |
| pipeTlast | output | 1 | Final beat of packet into the pipeline |
| exitTvalid | input | 1 | Exit tap: pipeline output valid |
| exitTready | input | 1 | Exit tap: downstream ready |
| exitTlast | input | 1 | Exit tap: final beat of packet |
| csrWrEn | input | 1 | Flow control register write strobe |
| csrWrData | input | REG_W | Write data (bit 0 request, bit 1 ignored) |
| csrRdData | output | REG_W | Read data (bit 0 request, bit 1 paused status) |

## Verification
The assertions watch, on every cycle, the properties that are local in time. A paused status never coincides with a beat offered into the pipeline. The entry cannot close between two beats of one packet. Upstream ready is never given without pipeline ready. A request-clearing write drops the status one cycle later. The count can neither wrap past its limit nor go below zero. Only the bench scenarios can show the end-to-end drain behaviour. These scenarios sweep the number of packets in flight and the packet lengths, and check that the status appears exactly when the last outstanding packet leaves. They also cover a request arriving mid-packet and a repeated request during a drain.

// File: rtl/pause_gate_pkg.sv
package pause_gate_pkg;
  localparam int unsigned REQ_BIT  = 0;
  localparam int unsigned STAT_BIT = 1;

  // control -> datapath strobes
  typedef struct packed {
    logic gateOpen;
  } gateCtl_t;

  // datapath -> control events
  typedef struct packed {
    logic entryBeat;
    logic entryLast;
    logic exitLast;
    logic pipeEmpty;
  } flowEvt_t;
endpackage

// File: rtl/pause_gate_ctrl.sv
module pause_gate_ctrl
  import pause_gate_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     csrWrEn,
  input  logic     csrWrReq,
  input  flowEvt_t evt,
  output gateCtl_t ctl,
  output logic     pauseReq,
  output logic     paused
);
  logic midPacket;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pauseReq  <= 1'b0;
      midPacket <= 1'b0;
    end else begin
      if (csrWrEn) pauseReq <= csrWrReq;
      if (evt.entryBeat) midPacket <= !evt.entryLast;
    end
  end

  // entry closes only between packets
  always_comb begin
    ctl.gateOpen = !pauseReq || midPacket;
    paused       = pauseReq && !midPacket && evt.pipeEmpty;
  end

  // R8: request only changes on a write
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !csrWrEn |=> pauseReq == $past(pauseReq));

  // R7: clearing the request opens the entry on the next cycle
  p_open_after_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn && !csrWrReq) |=> ctl.gateOpen);
endmodule

// File: rtl/pause_gate_dp.sv
module pause_gate_dp
  import pause_gate_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned MAX_INFLIGHT = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateCtl_t          ctl,
  output flowEvt_t          evt,
  input  logic              inTvalid,
  output logic              inTready,
  input  logic [DATA_W-1:0] inTdata,
  input  logic              inTlast,
  output logic              pipeTvalid,
  input  logic              pipeTready,
  output logic [DATA_W-1:0] pipeTdata,
  output logic              pipeTlast,
  input  logic              exitTvalid,
  input  logic              exitTready,
  input  logic              exitTlast
);
  localparam int unsigned CNT_W = $clog2(MAX_INFLIGHT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_INFLIGHT);

  logic [CNT_W-1:0] inFlight;
  logic incr, decr;

  assign pipeTvalid = inTvalid && ctl.gateOpen;
  assign inTready   = pipeTready && ctl.gateOpen;
  assign pipeTdata  = inTdata;
  assign pipeTlast  = inTlast;

  assign incr = pipeTvalid && pipeTready && pipeTlast;
  assign decr = exitTvalid && exitTready && exitTlast;

  always_ff @(posedge clk) begin
    if (!rstN)              inFlight <= '0;
    else if (incr && !decr) inFlight <= inFlight + 1'b1;
    else if (decr && !incr) inFlight <= inFlight - 1'b1;
  end

  always_comb begin
    evt.entryBeat = pipeTvalid && pipeTready;
    evt.entryLast = pipeTlast;
    evt.exitLast  = decr;
    evt.pipeEmpty = (inFlight == '0);
  end

  // R5: counter never wraps past its limit
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (incr && !decr) |-> inFlight != CNT_MAX);

  // R5: no departure without a packet accounted inside
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (decr && !incr) |-> inFlight != '0);
endmodule

// File: rtl/pkt_pause_gate.sv
module pkt_pause_gate
  import pause_gate_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned MAX_INFLIGHT = 15,
  parameter int unsigned REG_W        = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inTvalid,
  output logic              inTready,
  input  logic [DATA_W-1:0] inTdata,
  input  logic              inTlast,
  output logic              pipeTvalid,
  input  logic              pipeTready,
  output logic [DATA_W-1:0] pipeTdata,
  output logic              pipeTlast,
  input  logic              exitTvalid,
  input  logic              exitTready,
  input  logic              exitTlast,
  input  logic              csrWrEn,
  input  logic [REG_W-1:0]  csrWrData,
  output logic [REG_W-1:0]  csrRdData
);
  gateCtl_t ctl;
  flowEvt_t evt;
  logic pauseReq, paused;

  pause_gate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrWrReq(csrWrData[REQ_BIT]),
    .evt(evt), .ctl(ctl), .pauseReq(pauseReq), .paused(paused)
  );

  pause_gate_dp #(.DATA_W(DATA_W), .MAX_INFLIGHT(MAX_INFLIGHT)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .evt(evt),
    .inTvalid(inTvalid), .inTready(inTready), .inTdata(inTdata), .inTlast(inTlast),
    .pipeTvalid(pipeTvalid), .pipeTready(pipeTready), .pipeTdata(pipeTdata),
    .pipeTlast(pipeTlast), .exitTvalid(exitTvalid), .exitTready(exitTready),
    .exitTlast(exitTlast)
  );

  always_comb begin
    csrRdData           = '0;
    csrRdData[REQ_BIT]  = pauseReq;
    csrRdData[STAT_BIT] = paused;
  end

  // R6: a paused pipeline is offered no beat
  p_paused_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    csrRdData[STAT_BIT] |-> !pipeTvalid);

  // R4: entry cannot close between beats of one packet
  p_boundary_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pipeTvalid && pipeTready && !pipeTlast) |=> (!inTvalid || pipeTvalid));

  // R2: upstream ready never given without pipeline ready
  p_ready_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
    inTready |-> pipeTready);

  // R7: clearing write drops status next cycle
  p_resume_r7: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn && !csrWrData[REQ_BIT]) |=> !csrRdData[STAT_BIT]);

  // R8: repeated request keeps an established pause
  p_repeat_r8: assert property (@(posedge clk) disable iff (!rstN)
    (csrRdData[STAT_BIT] && csrWrEn && csrWrData[REQ_BIT]) |=> csrRdData[STAT_BIT]);
endmodule

// File: tb/pkt_pause_gate_tb.sv
`timescale 1ns/1ps
module pkt_pause_gate_tb;
  localparam int DATA_W = 8;
  localparam int REG_W  = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inTvalid = 0, inTlast = 0, pipeTready = 1;
  logic exitTvalid = 0, exitTready = 1, exitTlast = 0;
  logic csrWrEn = 0;
  logic [DATA_W-1:0] inTdata = '0;
  logic [REG_W-1:0]  csrWrData = '0;
  logic inTready, pipeTvalid, pipeTlast;
  logic [DATA_W-1:0] pipeTdata;
  logic [REG_W-1:0]  csrRdData;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk;

  pkt_pause_gate #(.DATA_W(DATA_W), .MAX_INFLIGHT(15), .REG_W(REG_W)) u_dut (
    .clk(clk), .rstN(rstN), .inTvalid(inTvalid), .inTready(inTready), .inTdata(inTdata),
    .inTlast(inTlast), .pipeTvalid(pipeTvalid), .pipeTready(pipeTready),
    .pipeTdata(pipeTdata), .pipeTlast(pipeTlast), .exitTvalid(exitTvalid),
    .exitTready(exitTready), .exitTlast(exitTlast), .csrWrEn(csrWrEn),
    .csrWrData(csrWrData), .csrRdData(csrRdData)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [DATA_W-1:0] d, input logic last);
    @(negedge clk); inTvalid = 1; inTdata = d; inTlast = last; #1;
    while (!inTready) begin @(negedge clk); #1; end
    @(posedge clk); #1; inTvalid = 0; inTlast = 0;
  endtask

  task automatic sendPkt(input int len, input int base);
    for (int i = 0; i < len; i++) beat(DATA_W'(base + i), (i == len - 1));
  endtask

  task automatic csrWrite(input logic [REG_W-1:0] v);
    @(negedge clk); csrWrEn = 1; csrWrData = v;
    @(negedge clk); csrWrEn = 0; #1;
  endtask

  task automatic exitBeat(input logic last);
    @(negedge clk); exitTvalid = 1; exitTlast = last;
    @(negedge clk); exitTvalid = 0; exitTlast = 0; #1;
  endtask

  task automatic statChk(input logic exp, input string req);
    chk(csrRdData[1] == exp, req, csrRdData[1], exp);
  endtask

  // probe the entry with a valid beat, withdrawn before the next edge
  task automatic gateChk(input logic expOpen, input string req);
    inTvalid = 1; #1;
    chk(pipeTvalid == expOpen && inTready == expOpen, req,
        {pipeTvalid, inTready}, {expOpen, expOpen});
    inTvalid = 0; #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1; #1;
    // R1: reset state
    chk(csrRdData == '0, "R1", csrRdData, 0);
    gateChk(1'b1, "R1");

    // R2: pass-through sweep while open
    for (int d = 0; d < 8; d++) begin
      for (int r = 0; r < 2; r++) begin
        @(negedge clk);
        inTdata = DATA_W'(d * 37); inTlast = 1'b0; pipeTready = r[0]; #1;
        inTvalid = 1; #1;
        chk(pipeTvalid == 1 && pipeTdata == DATA_W'(d * 37) && inTready == r[0],
            "R2", {pipeTvalid, pipeTdata, inTready}, {1'b1, DATA_W'(d * 37), r[0]});
        inTvalid = 0; #1;
      end
    end
    pipeTready = 1;

    // R3/R5/R6/R7: sweep packets in flight and lengths
    for (int n = 0; n < 4; n++) begin
      for (int len = 1; len < 4; len++) begin
        for (int p = 0; p < n; p++) sendPkt(len, p * 16);
        csrWrite(32'h1);
        gateChk(1'b0, "R3");
        statChk(n == 0, "R6");
        exitBeat(1'b0);                       // R5: non-last beat does not count
        statChk(n == 0, "R5");
        for (int k = n; k > 0; k--) begin
          statChk(1'b0, "R6");
          exitBeat(1'b1);
          statChk(k == 1, "R5");
        end
        csrWrite(32'h0);
        statChk(1'b0, "R7");
        gateChk(1'b1, "R7");
      end
    end

    // R4: request arrives mid-packet
    beat(8'hA0, 0);
    beat(8'hA1, 0);
    @(negedge clk); csrWrEn = 1; csrWrData = 32'h1; inTvalid = 1; inTdata = 8'hA2; inTlast = 0;
    @(posedge clk); #1; csrWrEn = 0; inTvalid = 0;
    @(negedge clk); #1;
    gateChk(1'b1, "R4");
    beat(8'hA3, 1);
    @(negedge clk); #1;
    gateChk(1'b0, "R4");
    statChk(1'b0, "R4");
    exitBeat(1'b1);
    statChk(1'b1, "R4");
    csrWrite(32'h0);

    // R8: repeated request during drain, bit 1 ignored
    sendPkt(2, 0);
    csrWrite(32'h1);
    csrWrite(32'h3);
    statChk(1'b0, "R8");
    chk(csrRdData == 32'h1, "R8", csrRdData, 32'h1);
    exitBeat(1'b1);
    statChk(1'b1, "R8");
    csrWrite(32'hFFFF_FFFF);
    chk(csrRdData == 32'h3, "R8", csrRdData, 32'h3);
    csrWrite(32'h2);
    chk(csrRdData == 32'h0, "R8", csrRdData, 32'h0);
    gateChk(1'b1, "R8");

    // R9: simultaneous entry and exit final beats
    sendPkt(1, 0);
    @(negedge clk); inTvalid = 1; inTlast = 1; exitTvalid = 1; exitTlast = 1;
    @(negedge clk); inTvalid = 0; inTlast = 0; exitTvalid = 0; exitTlast = 0;
    csrWrite(32'h1);
    statChk(1'b0, "R9");
    exitBeat(1'b1);
    statChk(1'b1, "R9");
    csrWrite(32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule